// File: doc/BRIEF.md
# Serially Loaded Synthesizer Divider Pair

This block lets a host configure a frequency synthesizer's two programmable dividers over three slow wires and then runs those dividers. The host presents each bit on a data wire, raises a serial clock to shift it in, and after a full 24-bit word raises a load strobe. The lowest two bits of the shifted word then pick one of four internal registers, and the word's upper bits are committed there.

Two of the registers set division ratios. One divides a reference count stream and the other divides a feedback count stream. Each stream arrives as a per-cycle tick in the system clock domain. Each divider emits a single-cycle pulse once per programmed number of ticks, ready for a phase comparator. The other two registers are plain control words driven straight to outputs. All three serial wires are brought into the system clock domain through two-flop synchronizers and edge detectors, so the system clock must run at least four times faster than the serial clock.

Top module: `synth_div_loader`

## Requirements
- R1: On synchronous reset both control-word outputs read zero and both dividers run with ratio 1, so every input tick after reset yields an output pulse.
- R2: The shift register is 24 bits deep and takes the synchronized data bit on each synchronized rising edge of the serial clock, most significant bit first; when more than 24 bits are sent, only the last 24 are kept.
- R3: A synchronized rising edge of the load strobe writes the shift register into the register whose number equals shifted bits [1:0]; every other register keeps its value, and the control outputs change at no other time.
- R4: Register 0 bits [15:2] set the reference ratio (1 to 16383) and register 1 bits [14:2] set the feedback ratio (1 to 8191); the word bits above those fields have no effect on the ratio.
- R5: Register 2 bits [23:2] drive output ctrl_a and register 3 bits [23:2] drive output ctrl_b.
- R6: Each divider raises its pulse output for exactly one system clock cycle, one cycle after the tick that completes a group of ratio-many ticks; cycles without a tick do not advance the count.
- R7: A programmed ratio of 0 behaves as ratio 1.
- R8: A newly written ratio takes effect only after the divider's current period ends at its terminal count, so the period in progress keeps the old length.
- R9: The largest ratios, 16383 for the reference and 8191 for the feedback, give exactly that many ticks per pulse.
- R10: No pulse appears in a cycle whose preceding cycle had no input tick on that divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock from the host, asynchronous |
| ser_data | input | 1 | Serial data bit, MSB first |
| ser_le | input | 1 | Load strobe; a rising edge commits the shifted word |
| ref_tick | input | 1 | One reference input cycle per high system clock cycle |
| fb_tick | input | 1 | One feedback input cycle per high system clock cycle |
| ref_pulse | output | 1 | Divided reference pulse |
| fb_pulse | output | 1 | Divided feedback pulse |
| ctrl_a | output | 22 | Control word from register 2 |
| ctrl_b | output | 22 | Control word from register 3 |

## Verification
On every cycle, the assertions check that the shift register moves only on a serial clock edge. They also check that the control words change only on a load edge and that a load to register 2 lands on ctrl_a. Both pulses must follow a tick, and the block must come out of reset with zeroed control words. The bench scenarios show the rest: MSB-first ordering and the discarding of surplus bits, and the positions of the ratio fields. They also show the mapping of zero to one, period lengths at random tick densities up to the largest ratios, and the rule that a write lands only at the next terminal count, even when it arrives in the middle of a period.

// File: rtl/synth_div_loader.sv
module synth_div_loader #(
  parameter int SW = 24,
  parameter int RW = 14,
  parameter int NW = 13,
  parameter int CW = SW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_clk,
  input  logic          ser_data,
  input  logic          ser_le,
  input  logic          ref_tick,
  input  logic          fb_tick,
  output logic          ref_pulse,
  output logic          fb_pulse,
  output logic [CW-1:0] ctrl_a,
  output logic [CW-1:0] ctrl_b
);

  logic [2:0]    sclk_q, le_q;
  logic [1:0]    dat_q;
  logic [SW-1:0] shreg;
  logic [RW-1:0] r_word, r_act, r_cnt;
  logic [NW-1:0] n_word, n_act, n_cnt;
  logic          sclk_rise, le_rise;
  logic [RW-1:0] r_eff;
  logic [NW-1:0] n_eff;

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign le_rise   = le_q[1] & ~le_q[2];
  assign r_eff     = (r_word == '0) ? RW'(1) : r_word;
  assign n_eff     = (n_word == '0) ? NW'(1) : n_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      le_q   <= '0;
      dat_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], ser_clk};
      le_q   <= {le_q[1:0], ser_le};
      dat_q  <= {dat_q[0], ser_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[SW-2:0], dat_q[1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_word <= '0;
      n_word <= '0;
      ctrl_a <= '0;
      ctrl_b <= '0;
    end else if (le_rise) begin
      case (shreg[1:0])
        2'd0:    r_word <= shreg[RW+1:2];
        2'd1:    n_word <= shreg[NW+1:2];
        2'd2:    ctrl_a <= shreg[SW-1:2];
        default: ctrl_b <= shreg[SW-1:2];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_cnt     <= '0;
      r_act     <= RW'(1);
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= 1'b0;
      if (ref_tick) begin
        if (r_cnt == r_act - RW'(1)) begin
          r_cnt     <= '0;
          r_act     <= r_eff;
          ref_pulse <= 1'b1;
        end else begin
          r_cnt <= r_cnt + RW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_cnt    <= '0;
      n_act    <= NW'(1);
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= 1'b0;
      if (fb_tick) begin
        if (n_cnt == n_act - NW'(1)) begin
          n_cnt    <= '0;
          n_act    <= n_eff;
          fb_pulse <= 1'b1;
        end else begin
          n_cnt <= n_cnt + NW'(1);
        end
      end
    end
  end

endmodule

module synth_div_loader_chk #(
  parameter int SW = 24,
  parameter int CW = SW - 2
) (
  input logic          clk,
  input logic          rst,
  input logic          sclk_rise,
  input logic          le_rise,
  input logic [SW-1:0] shreg,
  input logic          ref_tick,
  input logic          fb_tick,
  input logic          ref_pulse,
  input logic          fb_pulse,
  input logic [CW-1:0] ctrl_a,
  input logic [CW-1:0] ctrl_b
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_a == '0 && ctrl_b == '0 && !ref_pulse && !fb_pulse));

  assert_shift_only_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(shreg));

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !le_rise |=> ($stable(ctrl_a) && $stable(ctrl_b)));

  assert_ctrl_a_load_R5: assert property (@(posedge clk) disable iff (rst)
    (le_rise && shreg[1:0] == 2'd2) |=> (ctrl_a == $past(shreg[SW-1:2])));

  assert_ref_after_tick_R10: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |-> $past(ref_tick));

  assert_fb_after_tick_R10: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> $past(fb_tick));

endmodule

bind synth_div_loader synth_div_loader_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .le_rise(le_rise),
  .shreg(shreg), .ref_tick(ref_tick), .fb_tick(fb_tick),
  .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
  .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
);

// File: tb/tb_synth_div_loader.sv
module tb_synth_div_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic ref_tick = 1'b0, fb_tick = 1'b0;
  logic ref_pulse, fb_pulse;
  logic [21:0] ctrl_a, ctrl_b;

  int checks = 0;
  int errors = 0;
  int ts[2], act[2], prog[2];
  bit last_tk[2];
  logic [21:0] exp_a = '0, exp_b = '0;

  synth_div_loader dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_tick(ref_tick), .fb_tick(fb_tick), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
  );

  always #2 clk = ~clk;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [23:0] mk(input int addr, input int val);
    logic [23:0] w;
    w = 24'(val) << 2;
    w[1:0] = 2'(addr);
    return w;
  endfunction

  task automatic check(input string tag, input int actual, input int expected, input string what);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  task automatic drive_tick(input int which, input bit v);
    if (which == 0) ref_tick = v; else fb_tick = v;
    last_tk[which] = v;
    if (v) ts[which]++;
  endtask

  task automatic send_bits(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    ser_le = 1'b1;
    repeat (4) @(negedge clk);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_word(input logic [23:0] w);
    send_bits(24, {8'h00, w});
    case (w[1:0])
      2'd0: prog[0] = eff(int'(w[15:2]));
      2'd1: prog[1] = eff(int'(w[14:2]));
      2'd2: exp_a = w[23:2];
      default: exp_b = w[23:2];
    endcase
  endtask

  task automatic check_ctrl(input string tag);
    check(tag, int'(ctrl_a), int'(exp_a), "ctrl_a");
    check(tag, int'(ctrl_b), int'(exp_b), "ctrl_b");
  endtask

  task automatic run_div(input int which, input int np, input int pct, input string tag);
    int got = 0;
    while (got < np) begin
      bit p, tk;
      @(negedge clk);
      p = (which == 0) ? ref_pulse : fb_pulse;
      if (p) begin
        if (!last_tk[which]) begin
          errors++;
          $display("FAIL R10 pulse without tick: actual 1 expected 0");
        end
        check(tag, ts[which], act[which], "ticks per pulse");
        ts[which] = 0;
        act[which] = prog[which];
        got++;
      end
      tk = (got < np) && (($urandom % 100) < pct);
      drive_tick(which, tk);
    end
    @(negedge clk);
    drive_tick(which, 1'b0);
  endtask

  task automatic give_ticks(input int which, input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      drive_tick(which, 1'b1);
    end
    @(negedge clk);
    drive_tick(which, 1'b0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 2; i++) begin
      ts[i] = 0; act[i] = 1; prog[i] = 1; last_tk[i] = 0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check_ctrl("R1");
    run_div(0, 5, 100, "R1");
    run_div(1, 5, 60, "R1");

    write_word(mk(0, 5));
    run_div(0, 4, 70, "R8");
    write_word(mk(1, 9));
    run_div(1, 4, 50, "R8");

    give_ticks(0, 3);
    write_word(mk(0, 11));
    run_div(0, 3, 80, "R8");
    give_ticks(1, 6);
    write_word(mk(1, 2));
    run_div(1, 3, 80, "R8");

    write_word(mk(0, 0));
    run_div(0, 4, 90, "R7");
    write_word(mk(1, 0));
    run_div(1, 4, 90, "R7");

    write_word({8'hFF, 14'd3, 2'b00});
    run_div(0, 3, 100, "R4");
    write_word({9'h1FF, 13'd4, 2'b01});
    run_div(1, 3, 100, "R4");

    send_bits(28, {4'hF, mk(2, 22'h2A5A5)});
    exp_a = 22'h2A5A5;
    check_ctrl("R2");

    for (int i = 0; i < 8; i++) begin
      int sel = 2 + (i % 2);
      logic [21:0] v = 22'($urandom);
      write_word(mk(sel, int'(v)));
      check_ctrl((sel == 2) ? "R5" : "R3");
    end

    for (int i = 0; i < 6; i++) begin
      int which = i % 2;
      int rv = $urandom % 41;
      write_word(mk(which, rv));
      check_ctrl("R3");
      run_div(which, 3, 30 + ($urandom % 71), "R6");
    end

    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ref_pulse || fb_pulse) pulses++;
    end
    check("R10", pulses, 0, "pulses while idle");

    write_word(mk(0, 16383));
    run_div(0, 3, 100, "R9");
    write_word(mk(1, 8191));
    run_div(1, 3, 100, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule